// File: doc/BRIEF.md
# Power-Management Event Status and Interrupt Unit

This block keeps the power-management event status and event enable words and drives a level system control interrupt (`sci`) from them. Four event sources can raise it: a real-time-clock alarm, the power button, a global-lock release and a timer overflow. Each source arrives as a one-cycle pulse that latches its status bit. Software clears a latched bit by writing a one to that position. The interrupt is high while any source has both its status bit and its enable bit set.

Software reaches the two words through a 64-byte I/O window that can be moved. The window base comes from a 32-bit configuration dword, masked down to a 64-byte boundary within a 16-bit I/O space. A separate configuration enable bit turns decoding on and off. The block also tells an external overflow timer when an overflow interrupt should be scheduled: this is the case while the timer source is enabled and its status bit is still clear.

All pins are plain control and status pins. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. An I/O access completes in the cycle it is presented: writes take effect at that clock edge and read data is combinational.

Top module: `pm_event_sci`

## Requirements
- R1: After reset, the status and enable words read 0x0000, and both `sci` and `tmr_req` are low.
- R2: The window base is `cfg_base[15:6]` followed by six zero bits, and the window spans 64 bytes. Address bits [31:16] of the dword play no part. Accesses outside the window do not change any state and read as 0x0000.
- R3: The window decodes only while `cfg_ctl[0]` is 1. While it is 0, writes have no effect and reads return 0x0000.
- R4: The status word is at window offset 0x00 and the enable word is at window offset 0x02. In both words the bit positions are timer = 0, global lock = 5, power button = 8 and RTC = 10. All other bits read 0 and ignore writes. Other offsets hold nothing and read 0x0000.
- R5: An event pulse sets its status bit at the next clock edge, whatever the state of the enable bit.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If an event pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R8: `sci` is high exactly while at least one of the four sources has both its status bit and its enable bit set. It follows each status or enable change in the cycle after the clock edge that made the change.
- R9: `tmr_req` is high exactly while the timer enable bit is 1 and the timer status bit is 0.
- R10: `io_rdata` carries the selected word only while `io_rd` is high. At all other times it is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 32 | Configuration dword that holds the window base |
| cfg_ctl | input | 8 | Configuration byte; bit 0 enables the window |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe for one 16-bit word |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data; zero when no register is selected |
| ev_rtc | input | 1 | RTC alarm event pulse |
| ev_pwrbtn | input | 1 | Power button event pulse |
| ev_glock | input | 1 | Global lock release event pulse |
| ev_tmr | input | 1 | Timer overflow event pulse |
| sci | output | 1 | Level system control interrupt |
| tmr_req | output | 1 | Request to schedule a timer overflow interrupt |

## Verification
The interrupt is driven in several ways:
- Each source is raised on its own, with its enable bit off and then on. This separates latching a status bit from raising the interrupt, and shows that no source is mapped onto another's bit.
- Clear writes use a zero pattern, a one pattern, and a one that collides with a fresh pulse. This separates write-one-to-clear from a plain overwrite and shows that the event wins the collision.
- The timer enable and status bits are walked through their combinations to separate the schedule request from the interrupt.
- Window accesses go to just outside the window, into a moved window, and into a window whose enable bit is off. These separate true base masking and decoding from a fixed address or an ignored enable.

// File: rtl/pm_sci_pkg.sv
package pm_sci_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 16;
  localparam int CFG_W    = 32;
  localparam int WIN_BITS = 6;
  localparam int NUM_EV   = 4;

  // compact event index inside the block
  localparam int EV_TMR = 0;
  localparam int EV_GLK = 1;
  localparam int EV_PWR = 2;
  localparam int EV_RTC = 3;

  localparam logic [WIN_BITS-1:0] OFF_STS = 6'h00;
  localparam logic [WIN_BITS-1:0] OFF_EN  = 6'h02;

  typedef logic [NUM_EV-1:0] ev_vec_t;

  // position of a compact event bit inside the 16-bit software word
  function automatic int ev_pos(input int idx);
    case (idx)
      EV_TMR:  ev_pos = 0;
      EV_GLK:  ev_pos = 5;
      EV_PWR:  ev_pos = 8;
      default: ev_pos = 10;
    endcase
  endfunction
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode #(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 6,
  parameter logic [WIN_BITS-1:0] OFF_STS = '0,
  parameter logic [WIN_BITS-1:0] OFF_EN  = 2
) (
  input  logic [ADDR_W-WIN_BITS-1:0] base_hi,
  input  logic                       win_on,
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic                       sel_sts,
  output logic                       sel_en
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic [HI_W-1:0]     addr_hi;
  logic [WIN_BITS-1:0] addr_lo;

  assign addr_hi = addr[ADDR_W-1:WIN_BITS];
  assign addr_lo = addr[WIN_BITS-1:0];

  always_comb begin
    hit     = win_on && (addr_hi == base_hi);
    sel_sts = hit && (addr_lo == OFF_STS);
    sel_en  = hit && (addr_lo == OFF_EN);
  end

  always_comb begin
    assert (!(sel_sts && sel_en)) else $error("assert_one_select_R4");
  end
endmodule

// File: rtl/pm_evt_bank.sv
module pm_evt_bank #(
  parameter int NUM_EV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_pulse,
  input  logic              wr_sts,
  input  logic              wr_en,
  input  logic [NUM_EV-1:0] wd,
  output logic [NUM_EV-1:0] sts_q,
  output logic [NUM_EV-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) en_q <= wd;
  end

  for (genvar i = 0; i < NUM_EV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sts_q[i] <= 1'b0;
      else if (ev_pulse[i])       sts_q[i] <= 1'b1;
      else if (wr_sts && wd[i])   sts_q[i] <= 1'b0;
    end

    assert_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pulse[i] |=> sts_q[i]);
    assert_one_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && wd[i] && !ev_pulse[i]) |=> !sts_q[i]);
    assert_zero_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && !wd[i] && !ev_pulse[i]) |=> (sts_q[i] == $past(sts_q[i])));
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && wd[i] && ev_pulse[i]) |=> sts_q[i]);
  end
endmodule

// File: rtl/pm_sci_drive.sv
module pm_sci_drive #(
  parameter int NUM_EV  = 4,
  parameter int TMR_IDX = 0
) (
  input  logic [NUM_EV-1:0] sts,
  input  logic [NUM_EV-1:0] en,
  output logic              sci,
  output logic              tmr_req
);
  always_comb begin
    sci     = |(sts & en);
    tmr_req = en[TMR_IDX] && !sts[TMR_IDX];
  end
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
  import pm_sci_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_base,
  input  logic [7:0]        cfg_ctl,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              ev_rtc,
  input  logic              ev_pwrbtn,
  input  logic              ev_glock,
  input  logic              ev_tmr,
  output logic              sci,
  output logic              tmr_req
);
  logic    hit, sel_sts, sel_en;
  ev_vec_t ev_in, wd_ev, sts_q, en_q;
  logic [DATA_W-1:0] sts_word, en_word;
  logic unused_cfg;

  assign unused_cfg = ^{cfg_base[CFG_W-1:ADDR_W], cfg_base[WIN_BITS-1:0], cfg_ctl[7:1]};

  always_comb begin
    ev_in         = '0;
    ev_in[EV_TMR] = ev_tmr;
    ev_in[EV_GLK] = ev_glock;
    ev_in[EV_PWR] = ev_pwrbtn;
    ev_in[EV_RTC] = ev_rtc;
  end

  pm_win_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .OFF_STS(OFF_STS), .OFF_EN(OFF_EN)
  ) u_dec (
    .base_hi (cfg_base[ADDR_W-1:WIN_BITS]),
    .win_on  (cfg_ctl[0]),
    .addr    (io_addr),
    .hit     (hit),
    .sel_sts (sel_sts),
    .sel_en  (sel_en)
  );

  for (genvar i = 0; i < NUM_EV; i++) begin : g_map
    assign wd_ev[i] = io_wdata[ev_pos(i)];
  end

  always_comb begin
    sts_word = '0;
    en_word  = '0;
    for (int i = 0; i < NUM_EV; i++) begin
      sts_word[ev_pos(i)] = sts_q[i];
      en_word[ev_pos(i)]  = en_q[i];
    end
  end

  pm_evt_bank #(.NUM_EV(NUM_EV)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_pulse (ev_in),
    .wr_sts   (io_wr && sel_sts),
    .wr_en    (io_wr && sel_en),
    .wd       (wd_ev),
    .sts_q    (sts_q),
    .en_q     (en_q)
  );

  pm_sci_drive #(.NUM_EV(NUM_EV), .TMR_IDX(EV_TMR)) u_drv (
    .sts     (sts_q),
    .en      (en_q),
    .sci     (sci),
    .tmr_req (tmr_req)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd && sel_sts)     io_rdata = sts_word;
    else if (io_rd && sel_en) io_rdata = en_word;
  end

  assert_closed_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ctl[0] |-> (io_rdata == '0));
  assert_closed_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_ctl[0] && io_wr) |=> (en_q == $past(en_q)));
  assert_sci_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (en_q != '0));
  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0));
  assert_req_vs_sci_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_req && $countones(en_q) == 1) |-> !sci);
endmodule

// File: tb/tb_pm_event_sci.sv
`timescale 1ns/1ps
module tb_pm_event_sci;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] cfg_base = 32'h1234_5677;
  logic [7:0]  cfg_ctl = 8'h01;
  logic [15:0] io_addr = '0;
  logic        io_wr = 0, io_rd = 0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        ev_rtc = 0, ev_pwrbtn = 0, ev_glock = 0, ev_tmr = 0;
  logic        sci, tmr_req;
  int total = 0, bad = 0;

  localparam logic [15:0] STS = 16'h5640;
  localparam logic [15:0] ENR = 16'h5642;

  always #2.5 clk = ~clk;

  pm_event_sci dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    #1;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1 d = io_rdata;
    io_rd = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_tmr = 1;
      1: ev_glock = 1;
      2: ev_pwrbtn = 1;
      default: ev_rtc = 1;
    endcase
    @(negedge clk);
    {ev_tmr, ev_glock, ev_pwrbtn, ev_rtc} = '0;
    #1;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check(!sci && !tmr_req, "R1 outputs", {sci, tmr_req}, 0);
    rd(STS, d); check(d == 0, "R1 status", d, 0);
    rd(ENR, d); check(d == 0, "R1 enable", d, 0);
  endtask

  task automatic t_latch_and_sci();
    logic [15:0] d;
    pulse(2);
    rd(STS, d); check(d == 16'h0100, "R5 pwr latched while disabled", d, 16'h0100);
    check(!sci, "R8 no sci without enable", sci, 0);
    wr(ENR, 16'h0100);
    check(sci, "R8 sci after enable", sci, 1);
    wr(ENR, 16'h0000);
    check(!sci, "R8 sci drops with enable", sci, 0);
    wr(ENR, 16'hFFFF);
    rd(ENR, d); check(d == 16'h0521, "R4 enable reserved bits", d, 16'h0521);
    rd(16'h5644, d); check(d == 0, "R4 empty offset", d, 0);
    wr(ENR, 16'h0000);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    wr(STS, 16'hFEFF);
    rd(STS, d); check(d == 16'h0100, "R6 zero keeps", d, 16'h0100);
    wr(STS, 16'h0100);
    rd(STS, d); check(d == 0, "R6 one clears", d, 0);
  endtask

  task automatic t_collide();
    logic [15:0] d;
    @(negedge clk);
    io_addr = STS; io_wdata = 16'h0001; io_wr = 1; ev_tmr = 1;
    @(negedge clk);
    io_wr = 0; ev_tmr = 0;
    rd(STS, d); check(d == 16'h0001, "R7 event wins over clear", d, 16'h0001);
    wr(STS, 16'h0001);
    rd(STS, d); check(d == 0, "R7 later clear works", d, 0);
  endtask

  task automatic t_timer_req();
    wr(ENR, 16'h0001);
    check(tmr_req && !sci, "R9 request with enable and clear status", {tmr_req, sci}, 2);
    pulse(0);
    check(!tmr_req && sci, "R9 request drops on status", {tmr_req, sci}, 1);
    wr(STS, 16'h0001);
    check(tmr_req && !sci, "R9 request back after clear", {tmr_req, sci}, 2);
    wr(ENR, 16'h0000);
    check(!tmr_req, "R9 no request when disabled", tmr_req, 0);
  endtask

  task automatic t_each_source();
    logic [15:0] d;
    logic [15:0] pos [4] = '{16'h0001, 16'h0020, 16'h0100, 16'h0400};
    for (int k = 0; k < 4; k++) begin
      wr(ENR, pos[k]);
      pulse(k);
      rd(STS, d); check(d == pos[k], "R4 source position", d, pos[k]);
      check(sci, "R8 source raises sci", sci, 1);
      wr(ENR, ~pos[k]);
      check(!sci, "R8 other enables do not raise", sci, 0);
      wr(STS, pos[k]);
    end
    wr(ENR, 16'h0000);
  endtask

  task automatic t_window();
    logic [15:0] d;
    wr(16'h5680, 16'h0400);
    rd(ENR, d); check(d == 0, "R2 outside write ignored", d, 0);
    rd(16'h5600, d); check(d == 0, "R2 outside read zero", d, 0);
    cfg_base = 32'hABCD_00C0;
    wr(16'h00C2, 16'h0020);
    rd(16'h00C2, d); check(d == 16'h0020, "R2 moved window", d, 16'h0020);
    rd(ENR, d); check(d == 0, "R2 old window closed", d, 0);
    cfg_ctl = 8'hFE;
    wr(16'h00C2, 16'h0000);
    rd(16'h00C2, d); check(d == 0, "R3 read zero when off", d, 0);
    cfg_ctl = 8'h01;
    rd(16'h00C2, d); check(d == 16'h0020, "R3 write ignored when off", d, 16'h0020);
    @(negedge clk); io_addr = 16'h00C2; io_rd = 0; #1;
    check(io_rdata == 0, "R10 no read strobe", io_rdata, 0);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_latch_and_sci();
    t_clear();
    t_collide();
    t_timer_req();
    t_each_source();
    t_window();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule